// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that moves data between two clocks with no fixed relation. A producer writes on the write clock, a consumer reads on the read clock, and each side sees its own status flags. The read side has Empty and Almost Empty. The write side has Full and Almost Full. All four flags are active high.

Each almost-flag compares the occupancy against an offset register that can hold any word count. The offsets come up at 7 after reset, and the data bus can rewrite them one word at a time. A dual-purpose control input, `wr_ctl_aux`, is captured on every write-clock edge while reset is held. If it is high during reset, it later acts as a second write enable. If it is low during reset, it later acts as a load strobe. The load strobe steers the write data into the offset registers instead of the storage array.

The two pointers cross between the clock domains as Gray code through two-flop synchronizers. Each flag is therefore pessimistic: it can be late to release but is never late to assert. Depth must be a power of two, no larger than 256.

Top module: `pflag_async_fifo`

## Requirements
- R1: A read happens on a rising read-clock edge only when both `rd_en_a_n` and `rd_en_b_n` are low and `empty` is low. The oldest stored word then appears on `dout` after that edge, so words leave in the order they were written.
- R2: `empty` is high exactly when the read-side occupancy is zero. `full` is high exactly when the write-side occupancy equals DEPTH. Once both domains are idle for a few cycles, both flags match the true occupancy.
- R3: `almost_empty` is high when the read-side occupancy is at or below the empty offset.
- R4: `almost_full` is high when the free space seen on the write side is at or below the full offset.
- R5: After reset the FIFO is empty and both offsets hold 7.
- R6: In dual-enable mode (`wr_ctl_aux` high during reset), a word is stored only on a write-clock edge where `wr_en_n` is low, `wr_ctl_aux` is high and `full` is low. When `wr_ctl_aux` is low, the edge stores nothing.
- R7: In load mode (`wr_ctl_aux` low during reset), every write-clock edge with `wr_ctl_aux` low copies `din[AW:0]` into an offset register and pushes nothing into the FIFO. Here AW = log2(DEPTH), so this is `din[6:0]` at depth 64. The first load after reset writes the empty offset and the next writes the full offset, and the sequence then alternates. In load mode, a FIFO write uses `wr_en_n` low with `wr_ctl_aux` high.
- R8: No word is stored while `full` is high, and no read happens while `empty` is high. `dout` keeps its value when a read is blocked.
- R9: `full` is already high right after the write edge that fills the last slot. `empty` is already high right after the read edge that takes the last word. Each pointer's Gray code changes by at most one bit per cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write enable |
| wr_ctl_aux | input | 1 | Second write enable, or load strobe when low, depending on its level during reset |
| din | input | 9 | Write data, or an offset value during a load |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| dout | output | 9 | Registered read data |
| empty | output | 1 | No words visible to the read side |
| almost_empty | output | 1 | Read-side occupancy at or below the empty offset |
| almost_full | output | 1 | Write-side free space at or below the full offset |
| full | output | 1 | Write-side occupancy equals DEPTH |

## Verification
The bench builds the block at its default depth of 64 words, so every occupancy from 0 to 64 can be visited one word at a time. At each step the bench checks all four flags against thresholds it computes itself. The sweeps run with the default offsets and again with loaded values of 10 and 3, and 2 and 7. This puts both edges of each almost-flag, the wrap of the load sequence, and the reset of that sequence within reach. The 64-word depth also makes the overflow attempt on a full FIFO and the underflow attempt on an empty FIFO cheap to reach.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic {
    MODE_DUAL_EN = 1'b0,
    MODE_LOAD    = 1'b1
  } wr_mode_e;

  localparam int DEF_OFFSET = 7;
endpackage

// File: rtl/pfifo_ptr_sync.sv
module pfifo_ptr_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfifo_ram.sv
module pfifo_ram #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int WORDS = 1 << AW;
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= mem[raddr];
endmodule

// File: rtl/pfifo_wr_side.sv
module pfifo_wr_side
  import pfifo_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int W       = 9,
  parameter int OFF_RST = DEF_OFFSET,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          aux,
  input  logic [W-1:0]  din,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full,
  output logic [PW-1:0] empty_off
);
  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] free_words(logic [PW-1:0] w, logic [PW-1:0] r);
    return PW'(DEPTH) - (w - r);
  endfunction

  wr_mode_e      wmode;
  logic [PW-1:0] wbin, rbin_w, wcount, wfree, full_off;
  logic          ld_sel;
  logic          load_fire, wr_req;

  // mode captured on every edge while reset is held
  always_ff @(posedge wclk)
    if (!rst_n) wmode <= aux ? MODE_DUAL_EN : MODE_LOAD;

  assign rbin_w      = from_gray(rgray_s);
  assign wcount      = wbin - rbin_w;
  assign wfree       = free_words(wbin, rbin_w);
  assign full        = (wcount == PW'(DEPTH));
  assign almost_full = (wfree <= full_off);
  assign wr_req      = !wr_en_n && aux;
  assign wr_fire     = wr_req && !full;
  assign load_fire   = (wmode == MODE_LOAD) && !aux;
  assign waddr       = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin + PW'(1);
      wgray <= to_gray(wbin + PW'(1));
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      empty_off <= PW'(OFF_RST);
      full_off  <= PW'(OFF_RST);
      ld_sel    <= 1'b0;
    end else if (load_fire) begin
      if (ld_sel) full_off  <= din[PW-1:0];
      else        empty_off <= din[PW-1:0];
      ld_sel <= !ld_sel;
    end

  // R8
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wbin));
  // R7
  load_no_push_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    load_fire |=> $stable(wbin));
  // R2
  wr_count_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= PW'(DEPTH));
  // R4
  full_implies_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  // R9
  wr_gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/pfifo_rd_side.sv
module pfifo_rd_side #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_a_n,
  input  logic          rd_b_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] empty_off,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, wbin_r, rcount;

  assign wbin_r       = from_gray(wgray_s);
  assign rcount       = wbin_r - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= empty_off);
  assign rd_fire      = !rd_a_n && !rd_b_n && !empty;
  assign raddr        = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin + PW'(1);
      rgray <= to_gray(rbin + PW'(1));
    end

  // R8
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> $stable(rbin));
  // R2
  rd_count_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rcount <= PW'(DEPTH));
  // R3
  empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
  // R9
  rd_gray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int SYNC_N  = 2,
  parameter int OFF_RST = pfifo_pkg::DEF_OFFSET
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_ctl_aux,
  input  logic [DW-1:0] din,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, empty_off;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, rd_fire;

  pfifo_wr_side #(.DEPTH(DEPTH), .W(DW), .OFF_RST(OFF_RST)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .aux(wr_ctl_aux),
    .din(din), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
    .wr_fire(wr_fire), .full(full), .almost_full(almost_full),
    .empty_off(empty_off)
  );

  pfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_a_n(rd_en_a_n), .rd_b_n(rd_en_b_n),
    .wgray_s(wgray_s), .empty_off(empty_off), .rgray(rgray),
    .raddr(raddr), .rd_fire(rd_fire), .empty(empty),
    .almost_empty(almost_empty)
  );

  pfifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  pfifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  pfifo_ram #(.W(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(din),
    .rclk(rclk), .re(rd_fire), .raddr(raddr), .rdata(dout)
  );
endmodule

// File: tb/pflag_async_fifo_test.sv
module pflag_async_fifo_test;
  localparam int DEPTH = 64;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_en_n = 1'b1, wr_ctl_aux = 1'b1;
  logic [8:0] din = '0;
  logic       rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
  logic [8:0] dout;
  logic       empty, almost_empty, almost_full, full;

  int checks = 0, failures = 0;
  int seq_w = 0, seq_r = 0;

  always #4 wclk = ~wclk;
  always #5 rclk = ~rclk;

  pflag_async_fifo uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .wr_ctl_aux(wr_ctl_aux), .din(din), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .dout(dout), .empty(empty),
    .almost_empty(almost_empty), .almost_full(almost_full), .full(full)
  );

  function automatic logic [8:0] pat(int k);
    return 9'((k * 37 + 5) % 512);
  endfunction

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_word(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic do_reset(logic auxv);
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    wr_ctl_aux = auxv;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst_n = 1'b1; wr_ctl_aux = 1'b1;
    seq_r = seq_w;
    settle();
  endtask

  task automatic write_raw(logic [8:0] d, logic auxv);
    @(negedge wclk);
    wr_en_n = 1'b0; wr_ctl_aux = auxv; din = d;
    @(negedge wclk);
    wr_en_n = 1'b1; wr_ctl_aux = 1'b1;
  endtask

  task automatic load_off(logic [8:0] d);
    @(negedge wclk);
    wr_ctl_aux = 1'b0; din = d;
    @(negedge wclk);
    wr_ctl_aux = 1'b1;
  endtask

  task automatic read_raw(logic a, logic b);
    @(negedge rclk);
    rd_en_a_n = a; rd_en_b_n = b;
    @(negedge rclk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic fill_sweep(int eoff, int foff);
    for (int n = 1; n <= DEPTH; n++) begin
      write_raw(pat(seq_w), 1'b1);
      seq_w++;
      if (n == DEPTH) chk_bit("R9 full at filling edge", full, 1'b1);
      settle();
      chk_bit("R2 empty", empty, 1'b0);
      chk_bit("R2 full", full, n == DEPTH);
      chk_bit("R3 almost_empty", almost_empty, n <= eoff);
      chk_bit("R4 almost_full", almost_full, (DEPTH - n) <= foff);
    end
  endtask

  task automatic drain_sweep(int eoff, int foff);
    for (int n = DEPTH - 1; n >= 0; n--) begin
      read_raw(1'b0, 1'b0);
      chk_word("R1 data order", dout, pat(seq_r));
      seq_r++;
      if (n == 0) chk_bit("R9 empty at draining edge", empty, 1'b1);
      settle();
      chk_bit("R2 empty", empty, n == 0);
      chk_bit("R2 full", full, 1'b0);
      chk_bit("R3 almost_empty", almost_empty, n <= eoff);
      chk_bit("R4 almost_full", almost_full, (DEPTH - n) <= foff);
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // dual-enable mode
    do_reset(1'b1);
    chk_bit("R5 reset empty", empty, 1'b1);
    chk_bit("R5 reset full", full, 1'b0);
    chk_bit("R5 reset almost_empty", almost_empty, 1'b1);
    chk_bit("R5 reset almost_full", almost_full, 1'b0);

    fill_sweep(7, 7);   // R5 default offsets
    write_raw(9'h1AA, 1'b1);
    chk_bit("R8 still full", full, 1'b1);
    settle();
    drain_sweep(7, 7);  // R8: rejected word must not appear

    read_raw(1'b0, 1'b0);
    chk_word("R8 dout held on empty read", dout, pat(seq_r - 1));
    settle();
    chk_bit("R8 still empty", empty, 1'b1);

    write_raw(9'h055, 1'b0);
    settle();
    chk_bit("R6 aux low blocks write", empty, 1'b1);
    write_raw(9'h0AB, 1'b1);
    settle();
    chk_bit("R6 write with both enables", empty, 1'b0);
    read_raw(1'b0, 1'b1);
    settle();
    chk_bit("R1 single read enable ignored", empty, 1'b0);
    read_raw(1'b1, 1'b0);
    settle();
    chk_bit("R1 other read enable ignored", empty, 1'b0);
    read_raw(1'b0, 1'b0);
    chk_word("R6 written word", dout, 9'h0AB);
    settle();
    chk_bit("R1 empty after read", empty, 1'b1);

    // load mode: empty offset, full offset, then wrap to empty offset
    do_reset(1'b0);
    load_off(9'd20);
    load_off(9'd3);
    load_off(9'd10);
    settle();
    chk_bit("R7 loads push nothing", empty, 1'b1);
    chk_bit("R7 loads push nothing (ae)", almost_empty, 1'b1);
    fill_sweep(10, 3);

    // R7: load sequence restarts at the empty offset after reset
    do_reset(1'b0);
    chk_bit("R5 empty after reset", empty, 1'b1);
    load_off(9'd2);
    settle();
    fill_sweep(2, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule